// File: doc/BRIEF.md
# Processor Run-State Controller

This block decides, on every clock, what a 16-bit processor core is allowed to do. The core may advance its microcode, wait for the slave to finish a bus transfer, idle after a stop instruction, or freeze because an external agent asked it to halt. It can also pass through a one-cycle entry state that starts interrupt handling. The microcode sequencer gates its progress with the run enable. The exception logic watches the begin-interrupt and bus-fault request outputs to build its stack frames.

External interrupt requests are qualified against the current priority mask and registered as a pending level. A pending request is taken only at an instruction boundary, or at once while the core is stopped. When it is taken, its level is copied into a separate accepted-level register. That register keeps its value until the next interrupt is taken.

States, with the encoding seen on `state_o`: EXEC (0) runs microcode, ACK_WAIT (1) waits for the transfer acknowledge, STOPPED (2) idles after a stop, HALTED (3) freezes under halt, IRQ_ENTRY (4) hands over to interrupt entry. Transitions: EXEC→ACK_WAIT on a bus request; ACK_WAIT→EXEC on acknowledge or bus fault; ACK_WAIT→HALTED on acknowledge with halt high; EXEC→HALTED on cycle end with halt high; HALTED→EXEC when halt falls; EXEC→STOPPED on the stop strobe; EXEC→IRQ_ENTRY on dispatch with an interrupt pending; STOPPED→IRQ_ENTRY on a pending interrupt; IRQ_ENTRY→EXEC always.

Top module: `cpu_runstate_ctrl`

## Requirements
- R1: After reset `state_o` is 0 (EXEC), `run_en` is 1, and `irq_begin` and `berr_req` are 0.
- R2: In EXEC, `bus_req` moves the state to ACK_WAIT (1) on the next cycle. The state stays there while neither `dtack` nor `berr` is high, and `dtack` alone returns it to EXEC.
- R3: In ACK_WAIT, `berr` returns the state to EXEC even if `dtack` is also high, and `berr_req` is high for exactly the one cycle after that edge.
- R4: Halt takes effect only at the end of a bus cycle: in EXEC when `cyc_end` is high, or in ACK_WAIT when `dtack` completes the transfer. `halt` without either has no effect. HALTED (3) holds while `halt` is high, and the state is EXEC on the cycle after `halt` is seen low.
- R5: `stop_exec` in EXEC moves the state to STOPPED (2). The state remains there until an interrupt is pending, and then moves to IRQ_ENTRY (4).
- R6: An interrupt is pending when `ipl` is greater than `ipl_mask`, or when `ipl` is all ones (level 7, not maskable). `ipl` equal to the mask is not pending. The pending flag and level are registered one cycle after `ipl` is sampled. In EXEC a pending interrupt is taken only on a cycle with `dispatch` high.
- R7: IRQ_ENTRY lasts exactly one cycle, with `irq_begin` high and `irq_level` equal to the taken level, and is followed by EXEC. `irq_level` keeps that value until another interrupt is taken.
- R8: `run_en` is high in EXEC and IRQ_ENTRY and low in ACK_WAIT, STOPPED and HALTED.
- R9: In EXEC the causes are ranked as follows: halt at cycle end first, then `bus_req`, then `stop_exec`, then a dispatched interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Core starts a bus transfer that needs an acknowledge |
| dtack | input | 1 | Transfer acknowledge from the slave |
| berr | input | 1 | Bus fault from the slave |
| halt | input | 1 | External halt request |
| cyc_end | input | 1 | Strobe marking the end of the current bus cycle |
| stop_exec | input | 1 | Strobe: a stop instruction has executed |
| dispatch | input | 1 | Strobe: instruction boundary, next instruction about to dispatch |
| ipl | input | 3 | External interrupt priority level |
| ipl_mask | input | 3 | Current interrupt priority mask |
| run_en | output | 1 | Microcode may advance |
| state_o | output | 3 | Current run state encoding |
| irq_begin | output | 1 | Begin interrupt entry this cycle |
| irq_level | output | 3 | Accepted interrupt level |
| berr_req | output | 1 | One-cycle request to raise a bus-fault exception |

## Verification
The bench builds the block with its default 3-bit priority width. This places the unmaskable top level at 7, so the tests can compare a request equal to the mask, one above it, and level 7 against a mask of 7. With that width, every mask/level relation the qualifier decodes can be reached with small, readable values. It also covers each of the five states and the ranking between simultaneous causes in EXEC.

// File: rtl/cpu_runstate_pkg.sv
package cpu_runstate_pkg;

    localparam int STATE_W = 3;

    typedef enum logic [STATE_W-1:0] {
        RS_EXEC      = 3'd0,
        RS_ACK_WAIT  = 3'd1,
        RS_STOPPED   = 3'd2,
        RS_HALTED    = 3'd3,
        RS_IRQ_ENTRY = 3'd4
    } run_state_t;

endpackage

// File: rtl/runstate_irq_latch.sv
module runstate_irq_latch #(
    parameter int LVL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LVL_W-1:0] ipl,
    input  logic [LVL_W-1:0] ipl_mask,
    input  logic             take,
    output logic             pend_vld,
    output logic [LVL_W-1:0] pend_lvl,
    output logic [LVL_W-1:0] acc_lvl
);
    localparam logic [LVL_W-1:0] TOP_LVL = {LVL_W{1'b1}};

    logic qualify;

    always_comb begin
        qualify = (ipl > ipl_mask) || (ipl == TOP_LVL);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_vld <= 1'b0;
            pend_lvl <= '0;
        end else begin
            pend_vld <= qualify;
            pend_lvl <= ipl;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_lvl <= '0;
        end else if (take) begin
            acc_lvl <= pend_lvl;
        end
    end

    // R7: accepted level changes only when an interrupt is taken
    a_r7_acc_hold : assert property (@(posedge clk) disable iff (!rst_n)
        !take |=> $stable(acc_lvl));

    // R6: a taken interrupt must have been pending
    a_r6_take_pending : assert property (@(posedge clk) disable iff (!rst_n)
        take |-> pend_vld);

endmodule

// File: rtl/runstate_fsm.sv
module runstate_fsm
    import cpu_runstate_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_req,
    input  logic       dtack,
    input  logic       berr,
    input  logic       halt,
    input  logic       cyc_end,
    input  logic       stop_exec,
    input  logic       dispatch,
    input  logic       pend_vld,
    output logic       take,
    output run_state_t cur,
    output logic       run_en,
    output logic       irq_begin,
    output logic       berr_req
);
    run_state_t nxt;
    logic       fault_now;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur <= RS_EXEC;
        end else begin
            cur <= nxt;
        end
    end

    // next-state logic
    always_comb begin
        nxt       = cur;
        fault_now = 1'b0;
        unique case (cur)
            RS_EXEC: begin
                if (halt && cyc_end) begin
                    nxt = RS_HALTED;
                end else if (bus_req) begin
                    nxt = RS_ACK_WAIT;
                end else if (stop_exec) begin
                    nxt = RS_STOPPED;
                end else if (dispatch && pend_vld) begin
                    nxt = RS_IRQ_ENTRY;
                end
            end
            RS_ACK_WAIT: begin
                if (berr) begin
                    nxt       = RS_EXEC;
                    fault_now = 1'b1;
                end else if (dtack) begin
                    nxt = halt ? RS_HALTED : RS_EXEC;
                end
            end
            RS_STOPPED: begin
                if (pend_vld) begin
                    nxt = RS_IRQ_ENTRY;
                end
            end
            RS_HALTED: begin
                if (!halt) begin
                    nxt = RS_EXEC;
                end
            end
            RS_IRQ_ENTRY: begin
                nxt = RS_EXEC;
            end
            default: begin
                nxt = RS_EXEC;
            end
        endcase
        take = (nxt == RS_IRQ_ENTRY) && (cur != RS_IRQ_ENTRY);
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            berr_req <= 1'b0;
        end else begin
            berr_req <= fault_now;
        end
    end

    always_comb begin
        run_en    = (cur == RS_EXEC) || (cur == RS_IRQ_ENTRY);
        irq_begin = (cur == RS_IRQ_ENTRY);
    end

    // R2: no acknowledge and no fault keeps the wait
    a_r2_wait_hold : assert property (@(posedge clk) disable iff (!rst_n)
        (cur == RS_ACK_WAIT && !dtack && !berr) |=> (cur == RS_ACK_WAIT));

    // R3: bus fault in the wait leads to EXEC with a fault request
    a_r3_fault_exit : assert property (@(posedge clk) disable iff (!rst_n)
        (cur == RS_ACK_WAIT && berr) |=> (cur == RS_EXEC && berr_req));

    // R4: halt is held while the request stays high
    a_r4_halt_hold : assert property (@(posedge clk) disable iff (!rst_n)
        (cur == RS_HALTED && halt) |=> (cur == RS_HALTED));

    // R4: halt without a cycle end is ignored in EXEC
    a_r4_halt_boundary : assert property (@(posedge clk) disable iff (!rst_n)
        (cur == RS_EXEC && !cyc_end) |=> (cur != RS_HALTED));

    // R5: stopped stays stopped while nothing is pending
    a_r5_stop_hold : assert property (@(posedge clk) disable iff (!rst_n)
        (cur == RS_STOPPED && !pend_vld) |=> (cur == RS_STOPPED));

    // R6: no interrupt entry from EXEC without dispatch
    a_r6_dispatch_only : assert property (@(posedge clk) disable iff (!rst_n)
        (cur == RS_EXEC && !dispatch) |=> (cur != RS_IRQ_ENTRY));

    // R7: interrupt entry lasts a single cycle
    a_r7_entry_one : assert property (@(posedge clk) disable iff (!rst_n)
        (cur == RS_IRQ_ENTRY) |=> (cur == RS_EXEC));

    // R8: run enable is low in all waiting states
    a_r8_run_low : assert property (@(posedge clk) disable iff (!rst_n)
        (cur == RS_ACK_WAIT || cur == RS_STOPPED || cur == RS_HALTED) |-> !run_en);

endmodule

// File: rtl/cpu_runstate_ctrl.sv
module cpu_runstate_ctrl
    import cpu_runstate_pkg::*;
#(
    parameter int LVL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_req,
    input  logic             dtack,
    input  logic             berr,
    input  logic             halt,
    input  logic             cyc_end,
    input  logic             stop_exec,
    input  logic             dispatch,
    input  logic [LVL_W-1:0] ipl,
    input  logic [LVL_W-1:0] ipl_mask,
    output logic             run_en,
    output logic [STATE_W-1:0] state_o,
    output logic             irq_begin,
    output logic [LVL_W-1:0] irq_level,
    output logic             berr_req
);
    logic             pend_vld;
    logic [LVL_W-1:0] pend_lvl;
    logic             take;
    run_state_t       cur;

    runstate_irq_latch #(.LVL_W(LVL_W)) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .ipl      (ipl),
        .ipl_mask (ipl_mask),
        .take     (take),
        .pend_vld (pend_vld),
        .pend_lvl (pend_lvl),
        .acc_lvl  (irq_level)
    );

    runstate_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_req   (bus_req),
        .dtack     (dtack),
        .berr      (berr),
        .halt      (halt),
        .cyc_end   (cyc_end),
        .stop_exec (stop_exec),
        .dispatch  (dispatch),
        .pend_vld  (pend_vld),
        .take      (take),
        .cur       (cur),
        .run_en    (run_en),
        .irq_begin (irq_begin),
        .berr_req  (berr_req)
    );

    assign state_o = cur;

endmodule

// File: tb/cpu_runstate_ctrl_tb_top.sv
module cpu_runstate_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_req = 0, dtack = 0, berr = 0, halt = 0, cyc_end = 0;
    logic       stop_exec = 0, dispatch = 0;
    logic [2:0] ipl = 0, ipl_mask = 0;
    logic       run_en, irq_begin, berr_req;
    logic [2:0] state_o, irq_level;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    cpu_runstate_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .dtack(dtack), .berr(berr),
        .halt(halt), .cyc_end(cyc_end), .stop_exec(stop_exec), .dispatch(dispatch),
        .ipl(ipl), .ipl_mask(ipl_mask), .run_en(run_en), .state_o(state_o),
        .irq_begin(irq_begin), .irq_level(irq_level), .berr_req(berr_req)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1 state", state_o, 0);
        chk("R1 run_en", run_en, 1);
        chk("R1 irq_begin", irq_begin, 0);
        chk("R1 berr_req", berr_req, 0);
    endtask

    task automatic t_bus_wait();
        bus_req = 1; step(); bus_req = 0;
        chk("R2 enter wait", state_o, 1);
        chk("R8 run_en low in wait", run_en, 0);
        step(); step();
        chk("R2 hold wait", state_o, 1);
        dtack = 1; step(); dtack = 0;
        chk("R2 ack exit", state_o, 0);
        chk("R8 run_en high in exec", run_en, 1);
    endtask

    task automatic t_berr();
        bus_req = 1; step(); bus_req = 0;
        berr = 1; dtack = 1; step(); berr = 0; dtack = 0;
        chk("R3 fault exit", state_o, 0);
        chk("R3 fault request", berr_req, 1);
        step();
        chk("R3 fault pulse ends", berr_req, 0);
    endtask

    task automatic t_halt();
        halt = 1; step();
        chk("R4 halt ignored mid cycle", state_o, 0);
        cyc_end = 1; step(); cyc_end = 0;
        chk("R4 halted", state_o, 3);
        chk("R8 run_en low halted", run_en, 0);
        step(); step();
        chk("R4 halt held", state_o, 3);
        halt = 0; step();
        chk("R4 halt release", state_o, 0);
        bus_req = 1; step(); bus_req = 0;
        halt = 1; dtack = 1; step(); dtack = 0;
        chk("R4 halt at ack", state_o, 3);
        halt = 0; step();
        chk("R4 release after ack halt", state_o, 0);
    endtask

    task automatic t_stop();
        stop_exec = 1; step(); stop_exec = 0;
        chk("R5 stopped", state_o, 2);
        chk("R8 run_en low stopped", run_en, 0);
        ipl = 2; ipl_mask = 4; step(); step();
        chk("R5 masked keeps stop", state_o, 2);
        ipl = 5; step();
        chk("R6 one cycle latch", state_o, 2);
        step();
        chk("R5 wake to entry", state_o, 4);
        chk("R7 begin", irq_begin, 1);
        chk("R7 level", irq_level, 5);
        chk("R8 run_en entry", run_en, 1);
        ipl = 0; step();
        chk("R7 back to exec", state_o, 0);
        chk("R7 begin drops", irq_begin, 0);
        chk("R7 level held", irq_level, 5);
    endtask

    task automatic t_dispatch();
        ipl = 3; ipl_mask = 1; step(); step();
        chk("R6 no dispatch no entry", state_o, 0);
        dispatch = 1; step(); dispatch = 0;
        chk("R6 dispatch entry", state_o, 4);
        chk("R7 level 3", irq_level, 3);
        ipl = 0; step();
        chk("R7 exit", state_o, 0);
    endtask

    task automatic t_masked();
        ipl = 3; ipl_mask = 3; step();
        dispatch = 1; step(); dispatch = 0;
        chk("R6 equal level masked", state_o, 0);
        chk("R7 level unchanged", irq_level, 3);
        ipl = 7; ipl_mask = 7; step();
        dispatch = 1; step(); dispatch = 0;
        chk("R6 level 7 unmaskable", state_o, 4);
        chk("R7 level 7", irq_level, 7);
        ipl = 0; step();
        chk("R7 exit after nmi", state_o, 0);
    endtask

    task automatic t_prio();
        ipl = 6; ipl_mask = 0; step();
        bus_req = 1; stop_exec = 1; dispatch = 1; step();
        bus_req = 0; stop_exec = 0; dispatch = 0; ipl = 0;
        chk("R9 bus over stop and irq", state_o, 1);
        dtack = 1; step(); dtack = 0;
        chk("R9 back to exec", state_o, 0);
        halt = 1; cyc_end = 1; bus_req = 1; stop_exec = 1; step();
        cyc_end = 0; bus_req = 0; stop_exec = 0;
        chk("R9 halt wins", state_o, 3);
        halt = 0; step();
        chk("R9 exec after halt", state_o, 0);
        stop_exec = 1; ipl = 6; dispatch = 1; step();
        stop_exec = 0; dispatch = 0;
        chk("R9 stop over dispatch", state_o, 2);
        step();
        chk("R5 wake after stop", state_o, 4);
        ipl = 0; step();
        chk("R7 exit after wake", state_o, 0);
    endtask

    initial begin
        #50000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk); @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_bus_wait();
        t_berr();
        t_halt();
        t_stop();
        t_dispatch();
        t_masked();
        t_prio();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule